// File: doc/BRIEF.md
# System Reset Sequencing Controller

This block collects reset requests from several sources and turns them into one internal reset and one open-drain reset pin. The pin is read through `ext_pin_in` and pulled low through `ext_drive`. Each source belongs to one of two classes. Deferred sources are a qualified low on the external pin and a clock-failure request. They wait until the current bus cycle is over, and while they wait the bus-monitor enable is raised. Immediate sources are the watchdog timeout, a double bus fault and the software reset request. They raise the internal reset in the same cycle and give a one-cycle strobe that aborts any bus cycle in progress.

Each reset is stretched after its cause goes away. An external reset keeps the internal reset asserted for as long as the pin stays low, then the block drives the pin low itself for STRETCH_CYC clocks. Every other cause, power-up included, holds reset for HOLD_CYC + STRETCH_CYC clocks, or for as long as the request stays high if that is longer. When reset ends, the block waits RISE_CYC clocks for the pin to float high and then reads it again. If the pin is high, a one-cycle start-of-fetch pulse is issued. If the pin is still low, the block takes the external-reset path instead.

A single down-counter times every window. A state machine walks through these states: idle, wait-for-bus-end, external hold, stretch, rise wait and start. The power-up reset `por_n` is active-low and asynchronous, and it places the controller directly in the stretch state with the full count.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A high on `wdog_req`, `dbl_fault_req` or `rst_instr_req` raises `int_rst` in the same cycle. Outside an active stretch or external hold, it also raises `bus_abort` for exactly one cycle.
- R2: An immediate request that is high for W cycles, starting from idle, keeps `int_rst` high for max(1 + HOLD_CYC + STRETCH_CYC, W + 1) cycles. `ext_drive` is high for all of those cycles except the first.
- R3: A `clk_fail_req` seen in idle first enters a wait in which `bus_mon_en` is 1 and `int_rst` stays 0. The wait lasts until a cycle with `bus_active` low. In the cycle after that, `int_rst` and `ext_drive` rise together and stay for max(HOLD_CYC + STRETCH_CYC, remaining request length) cycles.
- R4: The pin passes through a SYNC_STAGES-flop synchronizer. An external low is recognized only after it has been seen for QUAL_CYC consecutive synchronized cycles. A low lasting QUAL_CYC - 1 cycles produces no reset and no start pulse.
- R5: Once an external low is recognized and the bus is idle, `int_rst` stays high while the synchronized pin is low. After the release, `ext_drive` is high for exactly STRETCH_CYC cycles and `int_rst` stays high through them.
- R6: After `int_rst` falls, `ctrl_inactive` is high for RISE_CYC cycles. If the pin then reads high, `start_fetch` pulses for one cycle RISE_CYC cycles after the fall, and `ctrl_inactive` remains high in that cycle.
- R7: If the pin is still low at the end of the rise window, `int_rst` rises again RISE_CYC cycles after its fall, with no `start_fetch`. The sequence then continues as in R5.
- R8: An immediate request that arrives while a clock-failure reset is waiting for bus end takes effect at once: `int_rst` goes high and `bus_abort` pulses in that cycle, whatever `bus_active` is.
- R9: `bus_tristate` is high in exactly the cycles in which `int_rst` is high.
- R10: While `por_n` is low, `int_rst` and `ext_drive` are 1. After release they stay high for HOLD_CYC + STRETCH_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| ext_pin_in | input | 1 | Level read back from the shared reset pin |
| wdog_req | input | 1 | Watchdog timeout request (immediate) |
| dbl_fault_req | input | 1 | Double bus fault request (immediate) |
| rst_instr_req | input | 1 | Software reset request (immediate) |
| clk_fail_req | input | 1 | Clock failure request (deferred) |
| bus_active | input | 1 | A bus cycle is in progress |
| int_rst | output | 1 | Internal reset to the rest of the chip |
| ext_drive | output | 1 | Pull the shared reset pin low |
| bus_mon_en | output | 1 | Enable the bus monitor while a deferred reset waits |
| bus_abort | output | 1 | One-cycle strobe ending the current bus cycle |
| bus_tristate | output | 1 | Float the bus while reset is active |
| ctrl_inactive | output | 1 | Controls inactive, data bus in read mode, before the first fetch |
| start_fetch | output | 1 | One-cycle pulse starting the reset vector fetch |

## Verification
The properties take for granted that the pin is a wired-AND of the external device and `ext_drive`, so that the pin reads low whenever the block drives it. They also assume that request inputs change only between clock edges. The bench builds the pin as exactly that wired-AND and drives every input a fixed time after the rising edge. Immediate requests arrive either from idle or during a deferred wait. Bus-busy spans are kept shorter than the recognition window, so the externally observed lengths follow the closed-form counts in the requirements.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BUS,
        ST_EXT_HOLD,
        ST_STRETCH,
        ST_RISE,
        ST_START
    } seq_state_e;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_low
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q[0] <= pin_in;
            for (int i = 1; i < STAGES; i++) begin
                sh_q[i] <= sh_q[i-1];
            end
        end
    end

    assign pin_low = ~sh_q[STAGES-1];
endmodule

// File: rtl/rst_src_class.sv
module rst_src_class #(
    parameter int N_IMM = 3
) (
    input  logic [N_IMM-1:0] imm_req,
    input  logic             defer_req,
    output logic             imm_any,
    output logic             hold_any
);
    logic [N_IMM:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < N_IMM; g++) begin : g_or
        assign chain[g+1] = chain[g] | imm_req[g];
    end

    assign imm_any  = chain[N_IMM];
    assign hold_any = chain[N_IMM] | defer_req;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int QUAL_CYC    = 590,
    parameter int HOLD_CYC    = 328,
    parameter int STRETCH_CYC = 512,
    parameter int RISE_CYC    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_pin_in,
    input  logic wdog_req,
    input  logic dbl_fault_req,
    input  logic rst_instr_req,
    input  logic clk_fail_req,
    input  logic bus_active,
    output logic int_rst,
    output logic ext_drive,
    output logic bus_mon_en,
    output logic bus_abort,
    output logic bus_tristate,
    output logic ctrl_inactive,
    output logic start_fetch
);
    localparam int SRC_CYC = HOLD_CYC + STRETCH_CYC;
    localparam int MAX_A   = (QUAL_CYC > SRC_CYC) ? QUAL_CYC : SRC_CYC;
    localparam int MAX_C   = (MAX_A > RISE_CYC) ? MAX_A : RISE_CYC;
    localparam int CW      = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic           from_ext;
    } regs_t;

    regs_t q, d;

    logic pin_low_raw, pin_low, imm_any, hold_any, abortable, cnt_zero;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .pin_in  (ext_pin_in),
        .pin_low (pin_low_raw)
    );

    rst_src_class #(.N_IMM(3)) u_class (
        .imm_req   ({rst_instr_req, dbl_fault_req, wdog_req}),
        .defer_req (clk_fail_req),
        .imm_any   (imm_any),
        .hold_any  (hold_any)
    );

    // the pin is not trusted while this block pulls it low
    assign pin_low   = pin_low_raw & (q.st != ST_STRETCH);
    assign cnt_zero  = (q.cnt == '0);
    assign abortable = (q.st == ST_IDLE) || (q.st == ST_WAIT_BUS) ||
                       (q.st == ST_RISE) || (q.st == ST_START);

    always_comb begin
        d = q;
        if (imm_any && abortable) begin
            d.st       = ST_STRETCH;
            d.cnt      = CW'(SRC_CYC - 1);
            d.from_ext = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (clk_fail_req) begin
                        d.st       = ST_WAIT_BUS;
                        d.from_ext = 1'b0;
                        d.cnt      = CW'(QUAL_CYC - 1);
                    end else if (pin_low) begin
                        if (cnt_zero) begin
                            d.st       = ST_WAIT_BUS;
                            d.from_ext = 1'b1;
                        end else begin
                            d.cnt = q.cnt - CW'(1);
                        end
                    end else begin
                        d.cnt = CW'(QUAL_CYC - 1);
                    end
                end
                ST_WAIT_BUS: begin
                    if (!bus_active) begin
                        if (q.from_ext) begin
                            d.st = ST_EXT_HOLD;
                        end else begin
                            d.st  = ST_STRETCH;
                            d.cnt = CW'(SRC_CYC - 1);
                        end
                    end
                end
                ST_EXT_HOLD: begin
                    if (!pin_low) begin
                        d.st  = ST_STRETCH;
                        d.cnt = CW'(STRETCH_CYC - 1);
                    end
                end
                ST_STRETCH: begin
                    if (!cnt_zero) begin
                        d.cnt = q.cnt - CW'(1);
                    end else if (!hold_any) begin
                        d.st  = ST_RISE;
                        d.cnt = CW'(RISE_CYC - 1);
                    end
                end
                ST_RISE: begin
                    if (clk_fail_req) begin
                        d.st       = ST_WAIT_BUS;
                        d.from_ext = 1'b0;
                    end else if (!cnt_zero) begin
                        d.cnt = q.cnt - CW'(1);
                    end else if (pin_low) begin
                        d.st = ST_EXT_HOLD;
                    end else begin
                        d.st = ST_START;
                    end
                end
                ST_START: begin
                    if (clk_fail_req) begin
                        d.st       = ST_WAIT_BUS;
                        d.from_ext = 1'b0;
                    end else begin
                        d.st  = ST_IDLE;
                        d.cnt = CW'(QUAL_CYC - 1);
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.st       <= ST_STRETCH;
            q.cnt      <= CW'(SRC_CYC - 1);
            q.from_ext <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign int_rst       = (q.st == ST_EXT_HOLD) || (q.st == ST_STRETCH) || imm_any;
    assign ext_drive     = (q.st == ST_STRETCH);
    assign bus_mon_en    = (q.st == ST_WAIT_BUS);
    assign bus_abort     = imm_any && abortable;
    assign bus_tristate  = int_rst;
    assign ctrl_inactive = ((q.st == ST_RISE) || (q.st == ST_START)) && !imm_any;
    assign start_fetch   = (q.st == ST_START) && !imm_any && !clk_fail_req;
endmodule

module rst_seq_chk (
    input logic clk,
    input logic por_n,
    input logic wdog_req,
    input logic dbl_fault_req,
    input logic rst_instr_req,
    input logic int_rst,
    input logic ext_drive,
    input logic bus_mon_en,
    input logic bus_abort,
    input logic bus_tristate,
    input logic ctrl_inactive,
    input logic start_fetch
);
    logic imm;
    assign imm = wdog_req | dbl_fault_req | rst_instr_req;

    // R1
    imm_rst_now_chk: assert property (@(posedge clk) disable iff (!por_n)
        imm |-> int_rst);

    // R1
    abort_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        bus_abort |=> !bus_abort);

    // R5
    drive_in_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        ext_drive |-> int_rst);

    // R3
    wait_no_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_mon_en && !imm) |-> !int_rst);

    // R6
    fetch_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        start_fetch |=> !start_fetch);

    // R6
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        start_fetch |-> (!int_rst && ctrl_inactive && !ext_drive));

    // R9
    release_inactive_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(bus_tristate) |-> ctrl_inactive);
endmodule

bind rst_seq_ctrl rst_seq_chk u_rst_seq_chk (
    .clk           (clk),
    .por_n         (por_n),
    .wdog_req      (wdog_req),
    .dbl_fault_req (dbl_fault_req),
    .rst_instr_req (rst_instr_req),
    .int_rst       (int_rst),
    .ext_drive     (ext_drive),
    .bus_mon_en    (bus_mon_en),
    .bus_abort     (bus_abort),
    .bus_tristate  (bus_tristate),
    .ctrl_inactive (ctrl_inactive),
    .start_fetch   (start_fetch)
);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
    localparam int QUAL = 590;
    localparam int HOLD = 328;
    localparam int STR  = 512;
    localparam int RISE = 14;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_low = 1'b0;
    logic wdog = 1'b0, dblf = 1'b0, instr = 1'b0, clkf = 1'b0, bus_act = 1'b0;
    logic int_rst, ext_drive, bus_mon_en, bus_abort, bus_tristate, ctrl_inactive, start_fetch;
    logic pin;

    assign pin = ~(ext_low | ext_drive);

    always #4 clk = ~clk;

    rst_seq_ctrl dut (
        .clk(clk), .por_n(por_n), .ext_pin_in(pin),
        .wdog_req(wdog), .dbl_fault_req(dblf), .rst_instr_req(instr),
        .clk_fail_req(clkf), .bus_active(bus_act),
        .int_rst(int_rst), .ext_drive(ext_drive), .bus_mon_en(bus_mon_en),
        .bus_abort(bus_abort), .bus_tristate(bus_tristate),
        .ctrl_inactive(ctrl_inactive), .start_fetch(start_fetch)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // episode observations
    int rise1, rise2, fall1, len1, len2, nrise, drv, mon, abrt, ci, tsbad, st_idx;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000", cyc);
            report();
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // kind: 0 wdog, 1 double fault, 2 reset request, 3 clock fail, 4 external, 5 power-up release
    task automatic episode(input int kind, input int w, input int b, input int n,
                           input int a2_at, input int lin_s, input int lin_e, input int cap);
        logic prev;
        prev = 1'b0;
        rise1 = -1; rise2 = -1; fall1 = -1; len1 = 0; len2 = 0; nrise = 0;
        drv = 0; mon = 0; abrt = 0; ci = 0; tsbad = 0; st_idx = -1;
        for (int s = 0; s < cap; s++) begin
            if (kind == 5 && s == 0) por_n = 1'b1;
            wdog    = (kind == 0 && s < w) || (a2_at == s);
            dblf    = (kind == 1 && s < w);
            instr   = (kind == 2 && s < w);
            clkf    = (kind == 3 && s < w);
            ext_low = (kind == 4 && s < n) || (s >= lin_s && s < lin_e);
            bus_act = (s < b);
            #1;
            if (int_rst && !prev) begin
                nrise++;
                if (nrise == 1) rise1 = s;
                if (nrise == 2) rise2 = s;
            end
            if (!int_rst && prev && nrise == 1) fall1 = s;
            if (int_rst && nrise == 1) len1++;
            if (int_rst && nrise == 2) len2++;
            drv   += int'(ext_drive);
            mon   += int'(bus_mon_en);
            abrt  += int'(bus_abort);
            ci    += int'(ctrl_inactive);
            tsbad += int'(bus_tristate != int_rst);
            prev = int_rst;
            if (start_fetch && st_idx < 0) st_idx = s;
            tick();
            if (st_idx >= 0) break;
        end
        wdog = 0; dblf = 0; instr = 0; clkf = 0; ext_low = 0; bus_act = 0;
        for (int i = 0; i < 4; i++) tick();
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int exp_rise(input int kind, input int b);
        if (kind == 3) return mx(1, b) + 1;
        if (kind == 4) return QUAL + 3;
        return 0;
    endfunction

    function automatic int exp_len(input int kind, input int w, input int b, input int n);
        if (kind <= 2) return mx(HOLD + STR + 1, w + 1);
        if (kind == 3) return mx(HOLD + STR, w - exp_rise(3, b) + 1);
        if (kind == 4) return mx(n + 2, QUAL + 3) + STR - (QUAL + 3) + 1;
        return HOLD + STR;
    endfunction

    function automatic int exp_drv(input int kind, input int w, input int b, input int n);
        if (kind <= 2) return exp_len(kind, w, b, n) - 1;
        if (kind == 4) return STR;
        return exp_len(kind, w, b, n);
    endfunction

    function automatic int exp_mon(input int kind, input int b);
        if (kind == 3) return mx(1, b);
        if (kind == 4) return 1;
        return 0;
    endfunction

    function automatic string tag_of(input int kind);
        case (kind)
            0, 1, 2: return "R2";
            3:       return "R3";
            4:       return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check_std(input int kind, input int w, input int b, input int n);
        int er, el;
        string t;
        er = exp_rise(kind, b);
        el = exp_len(kind, w, b, n);
        t  = tag_of(kind);
        chk(t, "rise cycle", rise1, er);
        chk(t, "reset length", len1, el);
        chk(t, "pin drive length", drv, exp_drv(kind, w, b, n));
        chk("R3", "bus monitor cycles", mon, exp_mon(kind, b));
        chk("R1", "abort strobes", abrt, (kind <= 2) ? 1 : 0);
        chk("R6", "start fetch cycle", st_idx, er + el + RISE);
        chk("R6", "inactive cycles", ci, RISE + 1);
        chk("R9", "tristate mismatches", tsbad, 0);
    endtask

    initial begin
        int kind, w, b, n;
        void'($urandom(32'h1D5E_ED01));
        for (int i = 0; i < 3; i++) tick();
        #1;
        // R10 reset state
        chk("R10", "int_rst in reset", int'(int_rst), 1);
        chk("R10", "ext_drive in reset", int'(ext_drive), 1);
        chk("R10", "start_fetch in reset", int'(start_fetch), 0);
        chk("R10", "bus_abort in reset", int'(bus_abort), 0);
        tick();

        // R10 power-up release
        episode(5, 0, 0, 0, -1, -1, -1, 3000);
        check_std(5, 0, 0, 0);

        // R4 pin low one cycle short of qualification
        episode(4, 0, 0, QUAL - 1, -1, -1, -1, 1300);
        chk("R4", "short pulse rise", rise1, -1);
        chk("R4", "short pulse start", st_idx, -1);
        chk("R4", "short pulse drive", drv, 0);

        // R4 exact qualification length
        episode(4, 0, 0, QUAL, -1, -1, -1, 3000);
        check_std(4, 0, 0, QUAL);

        // R5 long external hold
        episode(4, 0, 0, 1500, -1, -1, -1, 4000);
        check_std(4, 0, 0, 1500);

        // R3 clock fail waiting on a busy bus
        episode(3, 1, 25, 0, -1, -1, -1, 3000);
        check_std(3, 1, 25, 0);

        // R8 immediate request during a deferred wait
        episode(3, 1, 200, 0, 50, -1, -1, 3000);
        chk("R8", "rise cycle", rise1, 50);
        chk("R8", "abort strobes", abrt, 1);
        chk("R8", "bus monitor cycles", mon, 50);
        chk("R8", "reset length", len1, HOLD + STR + 1);
        chk("R8", "start fetch cycle", st_idx, 50 + HOLD + STR + 1 + RISE);

        // R7 pin still low after the rise window
        episode(0, 1, 0, 0, -1, 200, 1000, 4000);
        chk("R7", "first length", len1, HOLD + STR + 1);
        chk("R7", "gap before re-entry", rise2 - fall1, RISE);
        chk("R7", "second length", len2, 1000 + 2 + STR - (HOLD + STR + 1 + RISE) + 1);
        chk("R7", "pin drive total", drv, HOLD + STR + STR);
        chk("R7", "start fetch cycle", st_idx, 1000 + 3 + STR + RISE);
        chk("R7", "inactive cycles", ci, RISE + RISE + 1);

        // R1 R2 R3 R5 random mix
        for (int e = 0; e < 16; e++) begin
            kind = int'($urandom % 5);
            w    = 1 + int'($urandom % 1100);
            b    = int'($urandom % 40);
            n    = QUAL + int'($urandom % 600);
            if (kind == 4) b = 0;
            episode(kind, w, b, n, -1, -1, -1, 4000);
            check_std(kind, w, b, n);
        end

        report();
    end
endmodule